// File: doc/BRIEF.md
# UART Receive Interrupt Generator

This block sits beside a UART receive FIFO and turns its fill level into a single interrupt line. There are two receive interrupt sources. The level source fires when the FIFO fill crosses a programmable fraction of its depth. The idle source fires when one or more characters have waited below that fraction without a push or a pop for a fixed number of bit periods. Both sources latch into raw status bits. A mask decides which of them reach the `irq` output.

Software drives the block through a small word-addressed register bank. The bank holds a trigger-fraction select, a mask, read-only raw and masked status views, a write-ones-to-clear register, and a test control. When the test control is on, writes to the data address come out as push strobes into the receive FIFO. This lets a host pre-load the FIFO.

The idle source is a three-state machine:
- `ST_EMPTY`: the FIFO is empty and the counter is held at zero.
- `ST_WAIT`: characters are present and bit periods are being counted.
- `ST_FIRED`: the idle interval has elapsed and the raw bit has been set.

Its transitions are:
- *fill* (`ST_EMPTY`→`ST_WAIT`): the level becomes non-zero.
- *drain* (any state→`ST_EMPTY`): the level reaches zero.
- *activity* (`ST_WAIT`/`ST_FIRED`→`ST_WAIT`): a push or pop restarts the count.
- *expire* (`ST_WAIT`→`ST_FIRED`): the count has reached the idle interval while the level is below the trigger.

Top module: `uart_rxirq_gen`

## Requirements
- R1: After reset the raw status, mask, level-select code and test control all read zero, and `irq` and `test_push` are low.
- R2: The level-select field is bits [2:0] at address 0x34. Codes 0..4 give a trigger of DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 and 7·DEPTH/8. Codes 5..7 act as DEPTH/8. The level raw bit is set on the cycle the fill level becomes greater than or equal to the trigger.
- R3: The level raw bit clears by itself one cycle after the fill level drops below the trigger.
- R4: The idle raw bit is set once IDLE_BITS ticks of `bit_tick` have passed with 0 < level < trigger and no push or pop. Any push or pop restarts the count from zero.
- R5: While the FIFO is empty the count is held at zero, and the idle raw bit is cleared.
- R6: The mask at 0x38 enables the level source with bit 4 and the idle source with bit 6 (1 = enabled). The register at 0x40 reads raw AND mask. `irq` is the OR of the masked bits.
- R7: Writing ones to the 11-bit clear register at 0x44 clears the matching raw bits at that clock edge. Bit 4 clears the level bit and bit 6 clears the idle bit.
- R8: The raw status at 0x3C shows the level source in bit 4 and the idle source in bit 6. All other bits read zero.
- R9: Bit 1 of the test control at 0x80 enables test mode. In test mode, a write to address 0x00 raises `test_push` for that cycle with `test_byte` equal to write data [7:0]. With the bit clear, a data write causes no push.
- R10: When a raw bit's set condition and a clear write fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| fifo_level | input | LVL_W (5) | Current receive FIFO fill level |
| fifo_push | input | 1 | A character entered the FIFO |
| fifo_pop | input | 1 | A character left the FIFO |
| bit_tick | input | 1 | One pulse per serial bit period |
| test_push | output | 1 | Test-mode push strobe into the receive FIFO |
| test_byte | output | 8 | Byte pushed with `test_push` |
| irq | output | 1 | Combined masked receive interrupt |

## Verification
Two raw-status updates can fall in the same clock edge as a software clear.

The first case is an idle expiry. The bench counts bit-period ticks up to the exact edge on which the counter reaches the interval, then issues a clear write to bit 6 at that same edge.

The second case is a level crossing. The bench raises the fill level to the trigger in the cycle that carries a clear write to bit 4.

In both cases the raw register read back afterwards must show the bit still set, because the set condition takes priority over the clear.

// File: rtl/uart_rxirq_pkg.sv
package uart_rxirq_pkg;

    localparam int BUS_W = 16;

    localparam logic [7:0] ADDR_DATA  = 8'h00;
    localparam logic [7:0] ADDR_LVL   = 8'h34;
    localparam logic [7:0] ADDR_MASK  = 8'h38;
    localparam logic [7:0] ADDR_RAW   = 8'h3C;
    localparam logic [7:0] ADDR_MSK_S = 8'h40;
    localparam logic [7:0] ADDR_CLR   = 8'h44;
    localparam logic [7:0] ADDR_TEST  = 8'h80;

    localparam int BIT_LVL  = 4;
    localparam int BIT_IDLE = 6;
    localparam int BIT_TEST = 1;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FIRED = 2'd2
    } idle_state_t;

endpackage

// File: rtl/rxirq_trig.sv
module rxirq_trig #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [2:0]       code,
    input  logic [LVL_W-1:0] level,
    output logic             at_trig,
    output logic             nonempty
);
    localparam logic [LVL_W-1:0] T_EIGHTH  = LVL_W'(DEPTH / 8);
    localparam logic [LVL_W-1:0] T_QUARTER = LVL_W'(DEPTH / 4);
    localparam logic [LVL_W-1:0] T_HALF    = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] T_3Q      = LVL_W'((3 * DEPTH) / 4);
    localparam logic [LVL_W-1:0] T_7E      = LVL_W'((7 * DEPTH) / 8);

    logic [LVL_W-1:0] trig;

    always_comb begin
        unique case (code)
            3'd1:    trig = T_QUARTER;
            3'd2:    trig = T_HALF;
            3'd3:    trig = T_3Q;
            3'd4:    trig = T_7E;
            default: trig = T_EIGHTH;
        endcase
    end

    assign at_trig  = (level >= trig);
    assign nonempty = (level != '0);

endmodule

// File: rtl/rxirq_idle_fsm.sv
module rxirq_idle_fsm
    import uart_rxirq_pkg::*;
#(
    parameter int IDLE_BITS = 32,
    parameter int CNT_W     = $clog2(IDLE_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic at_trig,
    input  logic fifo_push,
    input  logic fifo_pop,
    input  logic bit_tick,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(IDLE_BITS);

    idle_state_t      state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             activity;

    assign activity = fifo_push | fifo_pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        expire = 1'b0;
        unique case (state)
            ST_EMPTY: if (nonempty) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!nonempty)      nxt = ST_EMPTY;
                else if (activity)  nxt = ST_WAIT;
                else if (cnt == CNT_END && !at_trig) begin
                    nxt    = ST_FIRED;
                    expire = 1'b1;
                end
            end
            ST_FIRED: begin
                if (!nonempty)     nxt = ST_EMPTY;
                else if (activity) nxt = ST_WAIT;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (state != ST_WAIT || nxt != ST_WAIT || activity)
            cnt <= '0;
        else if (bit_tick && cnt != CNT_END)
            cnt <= cnt + 1'b1;
    end

    AST_DRAIN_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> (state == ST_EMPTY)); // R5

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT) |=> (cnt == '0) || (state == ST_WAIT)); // R4

endmodule

// File: rtl/rxirq_regs.sv
module rxirq_regs
    import uart_rxirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             at_trig,
    input  logic             nonempty,
    input  logic             to_set,
    output logic [2:0]       lvl_code,
    output logic             test_push,
    output logic [7:0]       test_byte,
    output logic             irq
);
    logic             mask_lvl, mask_idle;
    logic             raw_lvl, raw_idle;
    logic             test_en;
    logic             at_trig_q;
    logic             lvl_set;
    logic             wr_lvl, wr_mask, wr_clr, wr_test, wr_data;
    logic [BUS_W-1:0] raw_word, mask_word;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[BUS_W-1:8];

    assign wr_lvl  = bus_wr && (bus_addr == ADDR_LVL);
    assign wr_mask = bus_wr && (bus_addr == ADDR_MASK);
    assign wr_clr  = bus_wr && (bus_addr == ADDR_CLR);
    assign wr_test = bus_wr && (bus_addr == ADDR_TEST);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);

    assign lvl_set = at_trig && !at_trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_code  <= 3'd0;
            mask_lvl  <= 1'b0;
            mask_idle <= 1'b0;
            test_en   <= 1'b0;
            at_trig_q <= 1'b0;
        end else begin
            at_trig_q <= at_trig;
            if (wr_lvl) lvl_code <= bus_wdata[2:0];
            if (wr_mask) begin
                mask_lvl  <= bus_wdata[BIT_LVL];
                mask_idle <= bus_wdata[BIT_IDLE];
            end
            if (wr_test) test_en <= bus_wdata[BIT_TEST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_lvl  <= 1'b0;
            raw_idle <= 1'b0;
        end else begin
            if (lvl_set)
                raw_lvl <= 1'b1;
            else if (!at_trig || (wr_clr && bus_wdata[BIT_LVL]))
                raw_lvl <= 1'b0;

            if (to_set)
                raw_idle <= 1'b1;
            else if (!nonempty || (wr_clr && bus_wdata[BIT_IDLE]))
                raw_idle <= 1'b0;
        end
    end

    always_comb begin
        raw_word            = '0;
        raw_word[BIT_LVL]   = raw_lvl;
        raw_word[BIT_IDLE]  = raw_idle;
        mask_word           = '0;
        mask_word[BIT_LVL]  = mask_lvl;
        mask_word[BIT_IDLE] = mask_idle;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_LVL:   bus_rdata = {{(BUS_W-3){1'b0}}, lvl_code};
            ADDR_MASK:  bus_rdata = mask_word;
            ADDR_RAW:   bus_rdata = raw_word;
            ADDR_MSK_S: bus_rdata = raw_word & mask_word;
            ADDR_TEST:  bus_rdata = {{(BUS_W-2){1'b0}}, test_en, 1'b0};
            default:    bus_rdata = '0;
        endcase
    end

    assign irq       = |(raw_word & mask_word);
    assign test_push = wr_data && test_en;
    assign test_byte = bus_wdata[7:0];

    AST_LVL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !at_trig |=> !raw_lvl); // R3

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> !raw_idle); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        to_set |=> raw_idle); // R10

    AST_CLR_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[BIT_LVL] && !lvl_set) |=> !raw_lvl); // R7

endmodule

// File: rtl/uart_rxirq_gen.sv
module uart_rxirq_gen
    import uart_rxirq_pkg::*;
#(
    parameter int  DEPTH     = 16,
    parameter int  IDLE_BITS = 32,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_push,
    input  logic             fifo_pop,
    input  logic             bit_tick,
    output logic             test_push,
    output logic [7:0]       test_byte,
    output logic             irq
);
    logic [2:0] lvl_code;
    logic       at_trig;
    logic       nonempty;
    logic       expire;

    rxirq_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trig (
        .code     (lvl_code),
        .level    (fifo_level),
        .at_trig  (at_trig),
        .nonempty (nonempty)
    );

    rxirq_idle_fsm #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .nonempty  (nonempty),
        .at_trig   (at_trig),
        .fifo_push (fifo_push),
        .fifo_pop  (fifo_pop),
        .bit_tick  (bit_tick),
        .expire    (expire)
    );

    rxirq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .at_trig   (at_trig),
        .nonempty  (nonempty),
        .to_set    (expire),
        .lvl_code  (lvl_code),
        .test_push (test_push),
        .test_byte (test_byte),
        .irq       (irq)
    );

endmodule

// File: tb/tb_uart_rxirq_gen.sv
module tb_uart_rxirq_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int IDLE_BITS  = 32;
    localparam int LVL_W      = $clog2(DEPTH + 1);
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 13;

    // {exp, code, level}: 16'h<exp><code><level>
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0001, 16'h1002, 16'h0103, 16'h1104, 16'h0207,
        16'h1208, 16'h030B, 16'h130C, 16'h040D, 16'h140E,
        16'h1502, 16'h0701, 16'h1602
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = 8'h00;
    logic [15:0]      bus_wdata = 16'h0;
    logic [15:0]      bus_rdata;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             fifo_push = 1'b0;
    logic             fifo_pop = 1'b0;
    logic             bit_tick = 1'b0;
    logic             test_push;
    logic [7:0]       test_byte;
    logic             irq;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rxirq_gen #(.DEPTH(DEPTH), .IDLE_BITS(IDLE_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_level(fifo_level),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .bit_tick(bit_tick),
        .test_push(test_push), .test_byte(test_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        reg_read(8'h3C, rd); check("R1 raw", rd, 16'h0);
        reg_read(8'h38, rd); check("R1 mask", rd, 16'h0);
        reg_read(8'h34, rd); check("R1 lvl", rd, 16'h0);
        reg_read(8'h80, rd); check("R1 test", rd, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 test_push", {15'b0, test_push}, 16'h0);

        // R2 trigger table walk
        for (int i = 0; i < NVEC; i++) begin
            fifo_level = '0;
            wait_cyc(1);
            reg_write(8'h34, {13'b0, VEC[i][10:8]});
            fifo_level = LVL_W'(VEC[i][4:0]);
            wait_cyc(2);
            reg_read(8'h3C, rd);
            check($sformatf("R2 vec%0d", i), rd, VEC[i][12] ? 16'h0010 : 16'h0000);
        end

        // R3 auto clear when level falls below trigger
        fifo_level = '0; wait_cyc(1);
        reg_write(8'h34, 16'h0);
        fifo_level = 5'd3; wait_cyc(2);
        reg_read(8'h3C, rd); check("R3 set", rd, 16'h0010);
        fifo_level = 5'd1; wait_cyc(1);
        reg_read(8'h3C, rd); check("R3 cleared", rd, 16'h0000);

        // R6 mask, masked status, irq
        fifo_level = 5'd2; wait_cyc(2);
        reg_write(8'h38, 16'h0010);
        reg_read(8'h40, rd); check("R6 masked", rd, 16'h0010);
        check("R6 irq on", {15'b0, irq}, 16'h1);
        reg_write(8'h38, 16'h0000);
        check("R6 irq masked", {15'b0, irq}, 16'h0);
        reg_read(8'h3C, rd); check("R8 raw kept", rd, 16'h0010);

        // R7 clear level bit; no re-set while level stays
        reg_write(8'h44, 16'h0010);
        wait_cyc(2);
        reg_read(8'h3C, rd); check("R7 lvl cleared", rd, 16'h0000);

        // R4 idle timeout with restart
        fifo_level = '0; wait_cyc(2);
        fifo_level = 5'd1; fifo_push = 1'b1; wait_cyc(1); fifo_push = 1'b0;
        tick_n(20);
        fifo_pop = 1'b1; wait_cyc(1); fifo_pop = 1'b0;
        tick_n(31);
        wait_cyc(2);
        reg_read(8'h3C, rd); check("R4 not yet", rd, 16'h0000);
        tick_n(1);
        wait_cyc(2);
        reg_read(8'h3C, rd); check("R4 R8 fired", rd, 16'h0040);
        reg_write(8'h38, 16'h0040);
        check("R6 irq idle", {15'b0, irq}, 16'h1);

        // R7 clear idle bit
        reg_write(8'h44, 16'h0040);
        wait_cyc(1);
        reg_read(8'h3C, rd); check("R7 idle cleared", rd, 16'h0000);
        check("R7 irq low", {15'b0, irq}, 16'h0);

        // R5 empty clears idle bit and holds the counter
        fifo_push = 1'b1; wait_cyc(1); fifo_push = 1'b0;
        tick_n(IDLE_BITS);
        wait_cyc(2);
        reg_read(8'h3C, rd); check("R4 refire", rd, 16'h0040);
        fifo_level = '0; wait_cyc(1);
        reg_read(8'h3C, rd); check("R5 empty clears", rd, 16'h0000);
        tick_n(40);
        fifo_level = 5'd1; wait_cyc(1);
        tick_n(31);
        wait_cyc(2);
        reg_read(8'h3C, rd); check("R5 count held", rd, 16'h0000);

        // R10 expiry and clear in the same cycle
        tick_n(1);
        reg_write(8'h44, 16'h0040);
        reg_read(8'h3C, rd); check("R10 idle set wins", rd, 16'h0040);

        // R10 level crossing and clear in the same cycle
        fifo_level = '0; wait_cyc(2);
        fifo_level = 5'd2;
        reg_write(8'h44, 16'h0010);
        reg_read(8'h3C, rd); check("R10 lvl set wins", rd, 16'h0010);

        // R9 test mode push
        bus_addr = 8'h00; bus_wdata = 16'h00A5; bus_wr = 1'b1; #1;
        check("R9 no push", {15'b0, test_push}, 16'h0);
        @(negedge clk); bus_wr = 1'b0;
        reg_write(8'h80, 16'h0002);
        reg_read(8'h80, rd); check("R9 test on", rd, 16'h0002);
        bus_addr = 8'h00; bus_wdata = 16'h005A; bus_wr = 1'b1; #1;
        check("R9 push", {15'b0, test_push}, 16'h1);
        check("R9 byte", {8'b0, test_byte}, 16'h005A);
        @(negedge clk); bus_wr = 1'b0; #1;
        check("R9 push ends", {15'b0, test_push}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule